// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Controller

This block stores per-output enable bits for a ten-way reference clock fan-out and applies them to the outputs. Software programs the bits over a standard-mode two-wire serial bus. The block acts as a slave that answers one fixed address pair: 0xD2 for writes and 0xD3 for reads. There is no sub-address. A write carries two header bytes that are acknowledged and then thrown away. The data bytes after them always fill configuration byte 0 first and then count upward. A read returns a length byte and then every configuration byte in order.

Each enable bit either lets its output follow the reference clock or parks that output low. Enable changes cross into the reference clock domain through a synchronizer. They are applied only while the reference clock is low, so no output ever shows a shortened pulse. An active-low pin tri-states all ten outputs at once, whatever the register contents. The serial side has no data stream at its edge, only plain control pins. The bus itself provides the pacing, so the block applies no back-pressure of its own. The bus lines are oversampled by the system clock `clk`.

Top module: `fanout_clk_enable`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). For any other first byte after a START it leaves SDA released during the acknowledge bit.
- R2: In a write, the two bytes after the address are acknowledged and discarded. Data byte n (counting from 0) then loads configuration byte n, and every data byte is acknowledged.
- R3: A STOP may follow any complete data byte. Bytes already received stay loaded, and configuration bytes not reached keep their previous values.
- R4: A read returns the value 7 first, then configuration bytes 0 to 6 in order. The bytes go out most significant bit first, and the master acknowledges each one.
- R5: After reset every configuration bit is 1. All ten outputs are then driven and follow the reference clock.
- R6: Output k is controlled by bit k of byte 0 for k = 0 to 3, by bit k of byte 1 for k = 4 to 7, and by bit k-2 of byte 2 for k = 8 and 9. All other bits are stored and read back but have no effect.
- R7: A control bit of 1 makes its output follow the reference clock. A control bit of 0 holds that output low.
- R8: While `out_en_n` is low, all ten output-enable lines are 0. While it is high, all ten are 1.
- R9: Data bytes after the seventh in one write are acknowledged and change no configuration byte.
- R10: An output only rises together with a rising edge of the reference clock and only falls together with a falling edge, so every pulse after an enable change is a full half period.
- R11: A STOP in the middle of a byte aborts the transfer and leaves every configuration byte unchanged.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| ref_clk | input | 1 | Reference clock that is fanned out |
| out_en_n | input | 1 | Active-low enable for all output drivers |
| clk_out | output | 10 | Gated copies of the reference clock |
| clk_out_oe | output | 10 | Per-output driver enable (1 = driven) |

## Verification
The SDA-drive property assumes that SCL stays low for many system clock cycles after each falling edge, well beyond the synchronizer delay. The stimulus keeps every bus quarter period at six system clock cycles to meet this. The pulse-shape properties assume that the reference clock and the system clock are free-running, with edges that are only sampled and never generated by the block. The bench drives the bus only while SCL is low, except for START and STOP. It never issues a START or STOP while the slave holds SDA low.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [2:0] {
    SP_IDLE,
    SP_RECV,
    SP_ACK,
    SP_SEND,
    SP_SEND_ACK
  } sp_state_t;

  localparam int unsigned HDR_BYTES = 2;

  // configuration byte holding the control bit of output k
  function automatic int unsigned out_byte(input int unsigned k);
    if (k < 4) return 0;
    else if (k < 8) return 1;
    else return 2;
  endfunction

  // bit position inside that byte
  function automatic int unsigned out_bit(input int unsigned k);
    if (k < 8) return k;
    else return k - 2;
  endfunction

endpackage

// File: rtl/fec_serial_port.sv
module fec_serial_port
  import fec_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS   = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IW         = $clog2(NUM_REGS + HDR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic [IW-1:0] rd_idx,
  input  logic [7:0]    rd_data
);

  localparam logic [IW-1:0] BC_SAT  = IW'(NUM_REGS + HDR_BYTES);
  localparam logic [IW-1:0] BC_HDR  = IW'(HDR_BYTES);
  localparam logic [IW-1:0] BC_NREG = IW'(NUM_REGS);
  localparam logic [IW-1:0] BC_ONE  = IW'(1);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_d, sda_d;
  logic scl_rise, scl_fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_sy[SYNC_STAGES-1];
  assign sda_s    = sda_sy[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  sp_state_t    st;
  logic [3:0]   bitc;
  logic [7:0]   shreg;
  logic         is_addr, is_read, nack;
  logic [IW-1:0] bcnt;
  logic [7:0]   tx_next;
  logic [IW-1:0] bcnt_inc;

  assign bcnt_inc = (bcnt == BC_SAT) ? bcnt : bcnt + BC_ONE;
  assign rd_idx   = bcnt - BC_ONE;
  assign wr_idx   = bcnt - BC_HDR;
  assign wr_data  = shreg;
  assign wr_en    = (st == SP_RECV) && scl_fall && (bitc == 4'd8) && !is_addr
                    && (bcnt >= BC_HDR) && (bcnt < BC_SAT);

  always_comb begin
    if (bcnt == '0)          tx_next = 8'(NUM_REGS);
    else if (bcnt > BC_NREG) tx_next = 8'hFF;
    else                     tx_next = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SP_IDLE;
      bitc    <= '0;
      shreg   <= '0;
      is_addr <= 1'b0;
      is_read <= 1'b0;
      nack    <= 1'b0;
      bcnt    <= '0;
    end else if (start_c) begin
      st      <= SP_RECV;
      bitc    <= '0;
      is_addr <= 1'b1;
      bcnt    <= '0;
    end else if (stop_c) begin
      st <= SP_IDLE;
    end else begin
      unique case (st)
        SP_RECV: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            bitc  <= bitc + 4'd1;
          end else if (scl_fall && bitc == 4'd8) begin
            bitc <= '0;
            if (is_addr) begin
              if (shreg[7:1] == DEV_ADDR) begin
                st      <= SP_ACK;
                is_read <= shreg[0];
              end else begin
                st <= SP_IDLE;
              end
            end else begin
              st   <= SP_ACK;
              bcnt <= bcnt_inc;
            end
          end
        end
        SP_ACK: begin
          if (scl_fall) begin
            is_addr <= 1'b0;
            if (is_read) begin
              shreg <= tx_next;
              bcnt  <= bcnt_inc;
              bitc  <= '0;
              st    <= SP_SEND;
            end else begin
              st <= SP_RECV;
            end
          end
        end
        SP_SEND: begin
          if (scl_fall) begin
            if (bitc == 4'd7) begin
              bitc <= '0;
              st   <= SP_SEND_ACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              bitc  <= bitc + 4'd1;
            end
          end
        end
        SP_SEND_ACK: begin
          if (scl_rise) nack <= sda_s;
          else if (scl_fall) begin
            if (nack) st <= SP_IDLE;
            else begin
              shreg <= tx_next;
              bcnt  <= bcnt_inc;
              st    <= SP_SEND;
            end
          end
        end
        default: st <= SP_IDLE;
      endcase
    end
  end

  assign sda_oe = (st == SP_ACK) || ((st == SP_SEND) && !shreg[7]);

endmodule

// File: rtl/fec_cfg_bank.sv
module fec_cfg_bank
  import fec_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned NUM_OUT  = 10,
  parameter int unsigned IW       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_data,
  output logic [NUM_OUT-1:0] en_o
);

  logic [7:0] regs [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[r] <= 8'hFF;
      else if (wr_en && wr_idx == IW'(r)) regs[r] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int r = 0; r < NUM_REGS; r++)
      if (rd_idx == IW'(r)) rd_data = regs[r];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_map
    localparam int unsigned BY = out_byte(k);
    localparam int unsigned BI = out_bit(k);
    assign en_o[k] = regs[BY][BI];
  end

endmodule

// File: rtl/fec_out_gate.sv
module fec_out_gate #(
  parameter int unsigned NUM_OUT     = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_req,
  input  logic               oe_n,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] oe_o
);

  logic [SYNC_STAGES*NUM_OUT-1:0] chain;
  logic [NUM_OUT-1:0] en_sync, en_low;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[(SYNC_STAGES-1)*NUM_OUT-1:0], en_req};
  end

  assign en_sync = chain[SYNC_STAGES*NUM_OUT-1 -: NUM_OUT];

  // enable is taken over only on the falling edge: the clock is low then
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) en_low <= '1;
    else        en_low <= en_sync;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_gate
    assign clk_o[k] = ref_clk & en_low[k];
    assign oe_o[k]  = oe_n;
  end

endmodule

// File: rtl/fanout_clk_enable.sv
module fanout_clk_enable
  import fec_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS    = 7,
  parameter int unsigned NUM_OUT     = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic               ref_clk,
  input  logic               out_en_n,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_oe
);

  localparam int unsigned IW = $clog2(NUM_REGS + HDR_BYTES + 1);

  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0]    wr_data, rd_data;
  logic [NUM_OUT-1:0] en_map;

  fec_serial_port #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS),
    .SYNC_STAGES(SYNC_STAGES), .IW(IW)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  fec_cfg_bank #(
    .NUM_REGS(NUM_REGS), .NUM_OUT(NUM_OUT), .IW(IW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .en_o(en_map)
  );

  fec_out_gate #(
    .NUM_OUT(NUM_OUT), .SYNC_STAGES(SYNC_STAGES)
  ) u_gate (
    .ref_clk(ref_clk), .rst_n(rst_n), .en_req(en_map), .oe_n(out_en_n),
    .clk_o(clk_out), .oe_o(clk_out_oe)
  );

endmodule

// File: rtl/fec_checker.sv
module fec_checker #(
  parameter int unsigned NUM_OUT = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic               ref_clk,
  input logic               out_en_n,
  input logic [NUM_OUT-1:0] clk_out,
  input logic [NUM_OUT-1:0] clk_out_oe
);

  assert_sda_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_all_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |-> (clk_out_oe == '0));

  assert_all_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (clk_out_oe == '1));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_pulse
    assert_rise_with_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out[k]) |-> $rose(ref_clk));
    assert_fall_with_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_out[k]) |-> $fell(ref_clk));
    assert_low_with_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_clk |-> !clk_out[k]);
  end

endmodule

bind fanout_clk_enable fec_checker #(.NUM_OUT(NUM_OUT)) u_fec_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .ref_clk(ref_clk), .out_en_n(out_en_n),
  .clk_out(clk_out), .clk_out_oe(clk_out_oe)
);

// File: tb/fanout_clk_enable_test.sv
`timescale 1ns/1ps
module fanout_clk_enable_test;

  localparam int Q = 30;        // bus quarter period in ns
  localparam int REF_HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, out_en_n = 1'b1;
  logic sda_oe;
  logic [9:0] clk_out, clk_out_oe;
  wire sda_line;
  assign sda_line = ~(m_low | sda_oe);

  always #2.5 clk = ~clk;
  always #(REF_HALF) ref_clk = ~ref_clk;

  fanout_clk_enable uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .ref_clk(ref_clk), .out_en_n(out_en_n),
    .clk_out(clk_out), .clk_out_oe(clk_out_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_reg [0:6];
  logic [7:0] wdat [0:9];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_mask();
    logic [9:0] m;
    for (int k = 0; k < 10; k++) begin
      if (k < 4)      m[k] = exp_reg[0][k];
      else if (k < 8) m[k] = exp_reg[1][k];
      else            m[k] = exp_reg[2][k-2];
    end
    return m;
  endfunction

  task automatic bus_start();
    m_low = 1'b0; scl = 1'b1; #(2*Q);
    m_low = 1'b1; #(2*Q);
    scl = 1'b0; #(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; #(Q);
    scl = 1'b1; #(2*Q);
    m_low = 1'b0; #(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; #(Q);
    scl = 1'b1; #(2*Q);
    scl = 1'b0; #(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; #(Q);
    scl = 1'b1; #(Q);
    b = sda_line; #(Q);
    scl = 1'b0; #(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] d, input logic ack_it);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack_it);
  endtask

  // write: address, two discarded header bytes, then n data bytes
  task automatic write_tx(input string req, input int n);
    logic a;
    logic all_ack = 1'b1;
    bus_start();
    put_byte(8'hD2, a); all_ack &= a;
    put_byte(8'h3C, a); all_ack &= a;
    put_byte(8'hC3, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      put_byte(wdat[i], a);
      all_ack &= a;
      if (i < 7) exp_reg[i] = wdat[i];
    end
    bus_stop();
    chk(req, 16'(all_ack), 16'd1);
  endtask

  task automatic read_all(input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD3, a);
    chk("R1 read address ack", 16'(a), 16'd1);
    get_byte(d, 1'b1);
    chk("R4 length byte", 16'(d), 16'd7);
    for (int r = 0; r < 7; r++) begin
      get_byte(d, r < 6);
      chk(req, {8'(r), d}, {8'(r), exp_reg[r]});
    end
    bus_stop();
  endtask

  task automatic check_outputs(input string req);
    repeat (8) @(posedge ref_clk);
    @(posedge ref_clk); #2;
    chk(req, {6'd0, clk_out}, {6'd0, exp_mask()});
    @(negedge ref_clk); #2;
    chk(req, {6'd0, clk_out}, 16'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    for (int r = 0; r < 7; r++) exp_reg[r] = 8'hFF;
    repeat (10) @(posedge clk);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);

    // R5: reset state
    #1;
    chk("R5 drivers on", {6'd0, clk_out_oe}, 16'h03FF);
    chk("R5 sda released", 16'(sda_oe), 16'd0);
    check_outputs("R5 all running");
    read_all("R5 reset readback");

    // R6/R7: sweep each output off alone
    for (int k = 0; k < 10; k++) begin
      for (int r = 0; r < 7; r++) wdat[r] = 8'hFF;
      if (k < 4)      wdat[0][k] = 1'b0;
      else if (k < 8) wdat[1][k] = 1'b0;
      else            wdat[2][k-2] = 1'b0;
      write_tx("R2 write acks", 7);
      check_outputs("R6 single output stopped");
    end
    read_all("R2 readback after sweep");

    // R7: all off, then a mixed pattern with reserved bits cleared
    wdat[0] = 8'h00; wdat[1] = 8'h00; wdat[2] = 8'h00;
    write_tx("R2 write acks", 3);
    check_outputs("R7 all stopped low");
    wdat[0] = 8'h0A; wdat[1] = 8'h50; wdat[2] = 8'h80;
    wdat[3] = 8'h12; wdat[4] = 8'h34; wdat[5] = 8'h56; wdat[6] = 8'h78;
    write_tx("R2 write acks", 7);
    check_outputs("R6 mixed pattern");
    read_all("R2 mixed readback");

    // R10: re-enable output 0 and measure its first pulse
    wdat[0] = 8'h0B;
    write_tx("R2 write acks", 1);
    begin
      time t0;
      @(posedge clk_out[0]); t0 = $time;
      @(negedge clk_out[0]);
      chk("R10 first pulse width", 16'($time - t0), 16'(REF_HALF));
    end

    // R3: stop after one byte keeps the rest
    wdat[0] = 8'hF5;
    write_tx("R3 write acks", 1);
    read_all("R3 untouched bytes kept");
    check_outputs("R3 outputs");

    // R9: nine data bytes, extra two dropped
    for (int i = 0; i < 10; i++) wdat[i] = 8'(8'h91 + 8'(i * 17));
    write_tx("R9 extra bytes acked", 9);
    read_all("R9 extra bytes dropped");

    // R11: STOP in mid-byte aborts
    bus_start();
    put_byte(8'hD2, a);
    put_byte(8'h00, a);
    put_byte(8'h00, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    read_all("R11 aborted byte not stored");

    // R8: tri-state pin
    out_en_n = 1'b0; #20;
    chk("R8 all tristated", {6'd0, clk_out_oe}, 16'd0);
    out_en_n = 1'b1; #20;
    chk("R8 all driven", {6'd0, clk_out_oe}, 16'h03FF);

    // R1: address sweep (read address covered by read_all)
    for (int v = 0; v < 256; v++) begin
      if (v != 8'hD3) begin
        bus_start();
        put_byte(8'(v), a);
        bus_stop();
        chk("R1 address ack", {8'(v), 7'd0, a}, {8'(v), 7'd0, (v == 8'hD2)});
      end
    end
    read_all("R1 sweep left bytes intact");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule